// File: doc/BRIEF.md
# Shared-Pin Function and Pull-Up Control Registers

This block holds the small control state that decides what drives one shared pin of a microcontroller's bus interface, and which input pins get a pull-up device. A two-location register file sits on a simple synchronous bus. The function register holds a reference-enable bit and a clock-select bit. The pull-up register holds one enable bit per port. The operating-mode code and an external bus-control bit, together with the stored bits, choose among four pin functions: general-purpose I/O, a calibration reference, an external data-enable strobe, or the bus clock inverted.

Write access to the function register depends on the mode. In a normal mode only the first write after reset lands. In a special mode the first write is dropped and every later write lands. A sticky flag records that a first write was attempted. The pull-up register can be read and written at any time, except in peripheral mode, where it is taken out of the map. Each port's enable bit reaches only those pins of that port whose direction bit marks them as inputs.

Top module: `pin_ctl_regs`

## Requirements
- R1: In a normal mode (`mode[2]`=0), the first write to the function register (address 0) after reset is stored, and every later write leaves it unchanged. Reads are always allowed.
- R2: In a special mode (`mode[2]`=1), the first write to the function register after reset is dropped, and every later write is stored.
- R3: In expanded mode (`mode[1:0]`=01) with `ndbe`=0 and the clock-select bit (address 0, bit 1) clear, `pin_func` is 2 (data enable) and `pin_drive` equals `ext_de`.
- R4: In expanded mode with `ndbe`=0 and the clock-select bit set, `pin_func` is 3 and `pin_drive` is the complement of `eclk` in the same cycle, with no register delay.
- R5: In single-chip mode (00 or 11), in peripheral mode (10), or when `ndbe`=1, the clock-select bit has no effect. The pin function is 1 (`pin_drive`=`cal_ref`) when the reference-enable bit (address 0, bit 0) is set, and 0 (`pin_drive`=`gpio_out`) otherwise.
- R6: `pu_en[p*8+i]` is set exactly when pull-up bit p (address 1, bit p) is set and `pin_dir[p*8+i]` is 0 (input). Output pins never get a pull-up.
- R7: In peripheral mode, reads of address 1 return 0, and writes to address 1 leave the stored pull-up bits unchanged.
- R8: Reset leaves the function register at 0 and the pull-up register at 4'b0100 (port 2 enabled). The write flag is clear.
- R9: Bits above bit 1 of address 0, and above bit 3 of address 1, read as 0 and ignore writes. An accepted write changes the read value and the pin function from the next clock edge onward.
- R10: The write flag is set by the first write attempt to address 0 in any mode, and it stays set. A special-mode first write followed by a switch to a normal mode leaves the register locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = function register, 1 = pull-up register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| mode | input | 3 | Bit 2 special; bits 1:0 00 single, 01 expanded, 10 peripheral, 11 single |
| ndbe | input | 1 | Disables the bus functions of the shared pin when set |
| pin_dir | input | 32 | Direction per pin, 1 = output |
| eclk | input | 1 | Bus clock |
| ext_de | input | 1 | External data-enable strobe |
| cal_ref | input | 1 | Calibration reference signal |
| gpio_out | input | 1 | General-purpose output value |
| pin_func | output | 2 | 0 GPIO, 1 calibration, 2 data enable, 3 inverted clock |
| pin_drive | output | 1 | Value driven on the shared pin |
| pu_en | output | 32 | Pull-up enable per pin |

## Verification
Two functions can meet in one cycle. A mode change, which alters the write rule and the pin mux at once, can land in the same cycle as a write to the function register. The write flag set by that write then governs every write that follows. The bench provokes this by making a first write in special mode and then switching to a normal mode. It also writes the pull-up register while peripheral mode hides it. A behavioural model checks, on every cycle, the read data, the pin function, the driven value at both `eclk` levels, and every pull-up enable.

// File: rtl/pin_ctl_pkg.sv
package pin_ctl_pkg;

    typedef enum logic [1:0] {
        FN_GPIO   = 2'd0,
        FN_CAL    = 2'd1,
        FN_DE     = 2'd2,
        FN_INVCLK = 2'd3
    } pin_fn_e;

    typedef enum logic [1:0] {
        MK_SINGLE   = 2'b00,
        MK_EXPANDED = 2'b01,
        MK_PERIPH   = 2'b10,
        MK_SINGLE_B = 2'b11
    } mode_kind_e;

    localparam logic ADDR_FUNC = 1'b0;
    localparam logic ADDR_PULL = 1'b1;

    typedef struct packed {
        logic ref_en;
        logic clk_sel;
        logic wrote;
    } func_state_t;

endpackage

// File: rtl/pin_ctl_func_reg.sv
module pin_ctl_func_reg
    import pin_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic special,
    input  logic wd_ref,
    input  logic wd_sel,
    output logic ref_en,
    output logic clk_sel
);

    func_state_t st_d, st_q;
    logic        accept;

    always_comb begin
        st_d   = st_q;
        accept = special ? st_q.wrote : !st_q.wrote;
        if (wr_en) begin
            st_d.wrote = 1'b1;
            if (accept) begin
                st_d.ref_en  = wd_ref;
                st_d.clk_sel = wd_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_en  = st_q.ref_en;
    assign clk_sel = st_q.clk_sel;

    AST_NORMAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !special && st_q.wrote) |=> ($stable(ref_en) && $stable(clk_sel))); // R1
    AST_SPECIAL_FIRST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && special && !st_q.wrote) |=> ($stable(ref_en) && $stable(clk_sel))); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wrote |=> st_q.wrote); // R10
    AST_FLAG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.wrote); // R10

endmodule

// File: rtl/pin_ctl_pull_reg.sv
module pin_ctl_pull_reg #(
    parameter int NUM_PORTS = 4,
    parameter logic [NUM_PORTS-1:0] RESET_VAL = 4'b0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 periph,
    input  logic [NUM_PORTS-1:0] wdata,
    output logic [NUM_PORTS-1:0] pull_q
);

    logic [NUM_PORTS-1:0] pull_d;

    always_comb begin
        pull_d = pull_q;
        if (wr_en && !periph) begin
            pull_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_q <= RESET_VAL;
        end else begin
            pull_q <= pull_d;
        end
    end

    AST_PERIPH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && periph) |=> $stable(pull_q)); // R7

endmodule

// File: rtl/pin_ctl_mux.sv
module pin_ctl_mux
    import pin_ctl_pkg::*;
(
    input  logic       ref_en,
    input  logic       clk_sel,
    input  logic [1:0] kind,
    input  logic       ndbe,
    input  logic       gpio_out,
    input  logic       cal_ref,
    input  logic       ext_de,
    input  logic       eclk,
    output pin_fn_e    fn,
    output logic       drive
);

    logic bus_fn_ok;

    always_comb begin
        bus_fn_ok = (kind == MK_EXPANDED) && !ndbe;
        if (bus_fn_ok) begin
            fn = clk_sel ? FN_INVCLK : FN_DE;
        end else begin
            fn = ref_en ? FN_CAL : FN_GPIO;
        end
        case (fn)
            FN_CAL:    drive = cal_ref;
            FN_DE:     drive = ext_de;
            FN_INVCLK: drive = !eclk;
            default:   drive = gpio_out;
        endcase
    end

endmodule

// File: rtl/pin_ctl_regs.sv
module pin_ctl_regs
    import pin_ctl_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int NUM_PORTS     = 4,
    parameter int PINS_PER_PORT = 8,
    parameter logic [NUM_PORTS-1:0] PULL_RESET = 4'b0100,
    localparam int NUM_PINS     = NUM_PORTS * PINS_PER_PORT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [2:0]          mode,
    input  logic                ndbe,
    input  logic [NUM_PINS-1:0] pin_dir,
    input  logic                eclk,
    input  logic                ext_de,
    input  logic                cal_ref,
    input  logic                gpio_out,
    output logic [1:0]          pin_func,
    output logic                pin_drive,
    output logic [NUM_PINS-1:0] pu_en
);

    logic                 special;
    logic [1:0]           kind;
    logic                 periph;
    logic                 wr_func;
    logic                 wr_pull;
    logic                 ref_en;
    logic                 clk_sel;
    logic [NUM_PORTS-1:0] pull_q;
    pin_fn_e              fn;

    always_comb begin
        special = mode[2];
        kind    = mode[1:0];
        periph  = (kind == MK_PERIPH);
        wr_func = bus_sel && bus_wr && (bus_addr == ADDR_FUNC);
        wr_pull = bus_sel && bus_wr && (bus_addr == ADDR_PULL);
    end

    pin_ctl_func_reg u_func (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_func),
        .special (special),
        .wd_ref  (bus_wdata[0]),
        .wd_sel  (bus_wdata[1]),
        .ref_en  (ref_en),
        .clk_sel (clk_sel)
    );

    pin_ctl_pull_reg #(
        .NUM_PORTS (NUM_PORTS),
        .RESET_VAL (PULL_RESET)
    ) u_pull (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_pull),
        .periph (periph),
        .wdata  (bus_wdata[NUM_PORTS-1:0]),
        .pull_q (pull_q)
    );

    pin_ctl_mux u_mux (
        .ref_en   (ref_en),
        .clk_sel  (clk_sel),
        .kind     (kind),
        .ndbe     (ndbe),
        .gpio_out (gpio_out),
        .cal_ref  (cal_ref),
        .ext_de   (ext_de),
        .eclk     (eclk),
        .fn       (fn),
        .drive    (pin_drive)
    );

    assign pin_func = fn;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_pin
            assign pu_en[p*PINS_PER_PORT+i] = pull_q[p] && !pin_dir[p*PINS_PER_PORT+i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_FUNC) begin
            bus_rdata[1:0] = {clk_sel, ref_en};
        end else if (!periph) begin
            bus_rdata[NUM_PORTS-1:0] = pull_q;
        end
    end

    AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pu_en & pin_dir) == 0); // R6
    AST_NON_EXP_NO_BUS_FN: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != MK_EXPANDED || ndbe) |-> (pin_func == FN_GPIO || pin_func == FN_CAL)); // R5
    AST_INVCLK_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_func == FN_INVCLK) |-> (pin_drive != eclk)); // R4
    AST_PERIPH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (periph && bus_addr == ADDR_PULL) |-> (bus_rdata == '0)); // R7

endmodule

// File: tb/pin_ctl_regs_tb.sv
module pin_ctl_regs_tb_top;

    localparam int NPIN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_addr = 1'b0;
    logic [7:0]      bus_wdata = 8'h00;
    logic [7:0]      bus_rdata;
    logic [2:0]      mode = 3'b001;
    logic            ndbe = 1'b0;
    logic [NPIN-1:0] pin_dir = '0;
    logic            eclk = 1'b0;
    logic            ext_de = 1'b0;
    logic            cal_ref = 1'b0;
    logic            gpio_out = 1'b0;
    logic [1:0]      pin_func;
    logic            pin_drive;
    logic [NPIN-1:0] pu_en;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    bit       m_ref, m_sel, m_wrote;
    bit [3:0] m_pu;

    always #5 clk = ~clk;

    pin_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode(mode), .ndbe(ndbe), .pin_dir(pin_dir), .eclk(eclk),
        .ext_de(ext_de), .cal_ref(cal_ref), .gpio_out(gpio_out),
        .pin_func(pin_func), .pin_drive(pin_drive), .pu_en(pu_en)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        int          kind = mode[1:0];
        int          exp_fn;
        bit          exp_drv;
        logic [7:0]  exp_rd;
        logic [31:0] exp_pu;
        string       fn_tag;
        if (kind == 1 && !ndbe) begin
            exp_fn = m_sel ? 3 : 2;
            fn_tag = m_sel ? "R4" : "R3";
        end else begin
            exp_fn = m_ref ? 1 : 0;
            fn_tag = "R5";
        end
        case (exp_fn)
            1: exp_drv = cal_ref;
            2: exp_drv = ext_de;
            3: exp_drv = !eclk;
            default: exp_drv = gpio_out;
        endcase
        check(pin_func == exp_fn[1:0], fn_tag, "pin_func", 32'(pin_func), 32'(exp_fn));
        check(pin_drive == exp_drv, fn_tag, "pin_drive", 32'(pin_drive), 32'(exp_drv));
        if (bus_addr == 1'b0) begin
            exp_rd = {6'b0, m_sel, m_ref};
            check(bus_rdata == exp_rd, "R9", "rdata func", 32'(bus_rdata), 32'(exp_rd));
        end else begin
            exp_rd = (kind == 2) ? 8'h00 : {4'b0, m_pu};
            check(bus_rdata == exp_rd, "R7", "rdata pull", 32'(bus_rdata), 32'(exp_rd));
        end
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 8; i++) begin
                exp_pu[p*8+i] = m_pu[p] & ~pin_dir[p*8+i];
            end
        end
        check(pu_en == exp_pu, "R6", "pu_en", pu_en, exp_pu);
    endtask

    task automatic tick();
        bit acc;
        for (int e = 0; e < 2; e++) begin
            eclk = e[0];
            #1;
            compare();
        end
        @(posedge clk);
        if (bus_sel && bus_wr) begin
            if (bus_addr == 1'b0) begin
                acc = mode[2] ? m_wrote : !m_wrote;
                m_wrote = 1'b1;
                if (acc) begin
                    m_ref = bus_wdata[0];
                    m_sel = bus_wdata[1];
                end
            end else if (mode[1:0] != 2'b10) begin
                m_pu = bus_wdata[3:0];
            end
        end
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic do_write(input logic a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic do_read(input logic a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        tick();
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        m_ref = 0; m_sel = 0; m_wrote = 0; m_pu = 4'b0100;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        apply_reset();
        // R8: reset values
        bus_addr = 1'b1; #1;
        check(bus_rdata == 8'h04, "R8", "pull reset", 32'(bus_rdata), 32'h04);
        bus_addr = 1'b0; #1;
        check(bus_rdata == 8'h00, "R8", "func reset", 32'(bus_rdata), 32'h00);
        do_read(1'b1);

        // R1: normal expanded, first write lands, later ignored
        mode = 3'b001; ndbe = 1'b0; ext_de = 1'b1;
        do_read(1'b0);
        do_write(1'b0, 8'hFF);            // R9: only bits 1:0 stored
        check(bus_rdata == 8'h03, "R9", "masked func", 32'(bus_rdata), 32'h03);
        do_read(1'b0);                    // R4 inverted clock
        do_write(1'b0, 8'h00);
        check(bus_rdata == 8'h03, "R1", "locked after first", 32'(bus_rdata), 32'h03);
        ndbe = 1'b1; cal_ref = 1'b1; do_read(1'b0);   // R5 ndbe overrides
        ndbe = 1'b0; mode = 3'b000; do_read(1'b0);    // R5 single chip
        mode = 3'b010; do_read(1'b0);                 // R5 peripheral

        // R2: special mode
        apply_reset();
        mode = 3'b101; ext_de = 1'b0; gpio_out = 1'b1;
        do_write(1'b0, 8'h02);
        check(bus_rdata == 8'h00, "R2", "first dropped", 32'(bus_rdata), 32'h00);
        do_write(1'b0, 8'h01);
        check(bus_rdata == 8'h01, "R2", "second stored", 32'(bus_rdata), 32'h01);
        do_write(1'b0, 8'h00);            // R3 data enable
        ext_de = 1'b1; do_read(1'b0);
        do_write(1'b0, 8'h02);
        mode = 3'b100; do_read(1'b0);

        // R10: special first attempt, then normal: locked
        apply_reset();
        mode = 3'b101;
        do_write(1'b0, 8'h03);
        mode = 3'b001;
        do_write(1'b0, 8'h03);
        check(bus_rdata == 8'h00, "R10", "locked after mode switch", 32'(bus_rdata), 32'h00);

        // R6 / R7: pull-ups
        mode = 3'b000;
        pin_dir = 32'h00FF_F00F;
        do_write(1'b1, 8'hFF);            // R9 upper bits ignored
        check(bus_rdata == 8'h0F, "R9", "masked pull", 32'(bus_rdata), 32'h0F);
        pin_dir = 32'hA5A5_0000; do_read(1'b1);
        do_write(1'b1, 8'h0A);
        pin_dir = 32'h0000_FFFF; do_read(1'b1);
        mode = 3'b010;
        do_write(1'b1, 8'h05);            // R7 ignored in peripheral
        check(bus_rdata == 8'h00, "R7", "hidden read", 32'(bus_rdata), 32'h00);
        mode = 3'b000;
        bus_addr = 1'b1; #1;
        check(bus_rdata == 8'h0A, "R7", "pull kept", 32'(bus_rdata), 32'h0A);
        do_read(1'b1);
        mode = 3'b110; do_write(1'b1, 8'h03);
        mode = 3'b100; do_read(1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule